// File: doc/BRIEF.md
# UART Receive/Transmit Queue Controller with DMA Request Generation

This block holds the character queues that sit between a UART's serial shifter and the system bus. It owns one receive queue and one transmit queue, a write-only control byte that switches the queues on or off, empties them and picks a receive threshold, and the logic that tells an external DMA engine when to move data. The shifter pushes received characters, with their error status, into the receive queue. Software or DMA pops them. The transmit side works the other way round.

With queuing switched off, each direction shrinks to a single holding slot, as on a classic single-buffered UART. With queuing on, each queue holds `DEPTH` entries. Two request styles are offered. In the plain style, requests follow occupancy. In the burst style, the receive request latches once the threshold is met or a character timeout is reported, and stays up until the queue is drained. In the burst style the transmit request stays up while there is any free slot.

Top module: `uart_fifo_dma`

## Requirements
- R1: After reset both queues are empty and queuing is off. `rx_dma_req`, `rx_trig`, both overrun flags and `rx_pop_data` are 0, and `tx_dma_req` is 1.
- R2: With queuing off, each direction holds one entry. `rx_dma_req` is 1 exactly when the receive slot is full and `tx_dma_req` is 1 exactly when the transmit slot is empty, whatever the mode bit (bit 3) was last set to.
- R3: A control write whose bit 0 differs from the current queuing state empties both queues and clears both overrun flags at that write's clock edge. A push in the same cycle is discarded.
- R4: A control write with bit 0 at 0 changes nothing but the queuing state. Bits 1 and 2 of such a write empty nothing, and the mode and threshold fields keep their earlier values.
- R5: With queuing on, a write with bit 0 at 1 and bit 1 at 1 empties only the receive queue. Bit 2 at 1 empties only the transmit queue. The other queue's contents are kept.
- R6: `rx_trig` is 1 whenever receive occupancy is at least the threshold. Bits 7:6 give the threshold: 00 gives 1 entry, 01 gives DEPTH/2 (16), 10 gives 3·DEPTH/4 (24) and 11 gives 7·DEPTH/8 (28). With queuing off, the threshold is 1.
- R7: With queuing on and bit 3 at 0, `rx_dma_req` is 1 while the receive queue is non-empty and `tx_dma_req` is 1 only while the transmit queue is empty.
- R8: With queuing on and bit 3 at 1, `rx_dma_req` rises as soon as occupancy reaches the threshold. It then stays 1 while entries are popped below the threshold, and falls in the cycle the queue becomes empty.
- R9: In the burst style, an `rx_timeout` pulse while the receive queue is non-empty raises `rx_dma_req` from the next clock edge, and it stays 1 until the queue is empty. A timeout with the queue empty raises nothing.
- R10: With queuing on and bit 3 at 1, `tx_dma_req` is 1 whenever the transmit occupancy is below DEPTH.
- R11: Each queue returns entries in push order. The receive entry carries its 3 error bits with the data. Popped data appears on `*_pop_data` from the clock edge of the pop.
- R12: A push into a full queue is discarded and sets that direction's overrun flag, which holds until that queue is emptied by a control write. A pop from an empty queue leaves `*_pop_data` unchanged.
- R13: Bits 5:4 and 31:8 of a control write have no effect.
- R14: A receive flush clears a latched burst-style receive request at the write's clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control write strobe |
| ctl_wdata | input | 32 | Control write value |
| rx_push | input | 1 | Push a received character |
| rx_push_data | input | 8 | Received character |
| rx_push_err | input | 3 | Error status of the received character |
| rx_pop | input | 1 | Pop the oldest received entry |
| rx_pop_data | output | 8 | Last popped received character |
| rx_pop_err | output | 3 | Error status of the last popped character |
| tx_push | input | 1 | Push a character to send |
| tx_push_data | input | 8 | Character to send |
| tx_pop | input | 1 | Pop the oldest character to send |
| tx_pop_data | output | 8 | Last popped transmit character |
| rx_timeout | input | 1 | Receive character-timeout pulse |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_trig | output | 1 | Receive occupancy at or above threshold |
| rx_count | output | 6 | Receive occupancy |
| tx_count | output | 6 | Transmit occupancy |
| rx_overrun | output | 1 | Receive push was discarded |
| tx_overrun | output | 1 | Transmit push was discarded |

## Verification
The request logic is driven four ways. Occupancy is walked up and down one step at a time under each mode, a timeout pulse is given with the queue empty and with it non-empty, a flush is issued while a burst request is latched, and the queues are filled completely to force the full and empty edges. Filling to exactly one below each threshold and then one more shows whether the field decoding and the comparison are off by one. Popping below the threshold in the burst style separates a latched request from a plain level comparison. Repeating the same pushes with queuing off, and with bit 3 in both states, shows whether the single-slot mode wrongly follows the mode bit.

// File: rtl/uart_fifo_dma_pkg.sv
package uart_fifo_dma_pkg;

    // Threshold selector, decoded from control bits 7:6
    typedef enum logic [1:0] {
        TRIG_SINGLE  = 2'b00,
        TRIG_HALF    = 2'b01,
        TRIG_THREE_Q = 2'b10,
        TRIG_SEVEN_E = 2'b11
    } trig_sel_e;

    // Retained control state
    typedef struct packed {
        logic      fifo_on;
        logic      burst_mode;
        trig_sel_e trig;
    } ctl_state_t;

    // One-cycle queue empty strobes
    typedef struct packed {
        logic rx;
        logic tx;
    } flush_t;

    localparam int CTL_EN_BIT    = 0;
    localparam int CTL_RXCLR_BIT = 1;
    localparam int CTL_TXCLR_BIT = 2;
    localparam int CTL_MODE_BIT  = 3;
    localparam int CTL_TRIG_LSB  = 6;

    function automatic int unsigned trig_level(trig_sel_e s, int unsigned depth);
        case (s)
            TRIG_SINGLE:  return 1;
            TRIG_HALF:    return depth / 2;
            TRIG_THREE_Q: return (depth * 3) / 4;
            default:      return (depth * 7) / 8;
        endcase
    endfunction

endpackage

// File: rtl/ufd_ctrl.sv
module ufd_ctrl
    import uart_fifo_dma_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       we,
    input  logic [7:0] wbyte,
    output ctl_state_t ctl,
    output flush_t     flush
);

    logic en_w;
    logic toggle;

    always_comb begin
        en_w     = wbyte[CTL_EN_BIT];
        toggle   = we && (en_w != ctl.fifo_on);
        flush.rx = toggle || (we && en_w && wbyte[CTL_RXCLR_BIT]);
        flush.tx = toggle || (we && en_w && wbyte[CTL_TXCLR_BIT]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl.fifo_on    <= 1'b0;
            ctl.burst_mode <= 1'b0;
            ctl.trig       <= TRIG_SINGLE;
        end else if (we) begin
            ctl.fifo_on <= en_w;
            if (en_w) begin
                ctl.burst_mode <= wbyte[CTL_MODE_BIT];
                ctl.trig       <= trig_sel_e'(wbyte[CTL_TRIG_LSB +: 2]);
            end
        end
    end

    // R4: a write with the enable bit low keeps mode and threshold
    a_r4_fields_kept: assert property (@(posedge clk) disable iff (rst)
        (we && !wbyte[CTL_EN_BIT]) |=> ($stable(ctl.burst_mode) && $stable(ctl.trig)));

endmodule

// File: rtl/ufd_fifo.sv
module ufd_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 32,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             single,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] pop_data,
    output logic [CNT_W-1:0] count,
    output logic             overrun
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] cap;
    logic             full, push_ok, pop_ok;

    function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        cap     = single ? CNT_W'(1) : CNT_W'(DEPTH);
        full    = (count >= cap);
        push_ok = push && !full;
        pop_ok  = pop && (count != '0);
    end

    always_ff @(posedge clk) begin
        if (push_ok && !flush) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            count    <= '0;
            overrun  <= 1'b0;
            pop_data <= '0;
        end else if (flush) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count   <= '0;
            overrun <= 1'b0;
        end else begin
            if (push_ok) begin
                wr_ptr <= bump(wr_ptr);
            end
            if (pop_ok) begin
                rd_ptr   <= bump(rd_ptr);
                pop_data <= mem[rd_ptr];
            end
            if (push && full) begin
                overrun <= 1'b1;
            end
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R12: occupancy never passes the current capacity
    a_r12_bounded: assert property (@(posedge clk) disable iff (rst)
        !flush |=> (count <= cap));

    // R12: push into a full queue is dropped and flagged
    a_r12_full_drop: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop && !flush) |=> (count == $past(count) && overrun));

    // R12: pop from an empty queue keeps the last value
    a_r12_empty_pop: assert property (@(posedge clk) disable iff (rst)
        (pop && count == '0) |=> $stable(pop_data));

    // R3: a flush leaves the queue empty
    a_r3_flush_empty: assert property (@(posedge clk) disable iff (rst)
        flush |=> (count == '0 && !overrun));

endmodule

// File: rtl/ufd_dma.sv
module ufd_dma
    import uart_fifo_dma_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  ctl_state_t       ctl,
    input  logic             flush_rx,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] tx_count,
    input  logic             rx_timeout,
    output logic             rx_trig,
    output logic             rx_req,
    output logic             tx_req
);

    logic             burst;
    logic             rx_nonempty;
    logic [CNT_W-1:0] thr;
    logic             hold_q, hold_d;

    always_comb begin
        burst       = ctl.fifo_on && ctl.burst_mode;
        rx_nonempty = (rx_count != '0);
        thr         = ctl.fifo_on ? CNT_W'(trig_level(ctl.trig, DEPTH)) : CNT_W'(1);
        rx_trig     = (rx_count >= thr);
    end

    // Latch for the burst-style receive request
    always_comb begin
        if (flush_rx || !burst || !rx_nonempty) begin
            hold_d = 1'b0;
        end else if (rx_trig || rx_timeout) begin
            hold_d = 1'b1;
        end else begin
            hold_d = hold_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= 1'b0;
        end else begin
            hold_q <= hold_d;
        end
    end

    always_comb begin
        if (burst) begin
            rx_req = rx_trig || (hold_q && rx_nonempty);
            tx_req = (tx_count < CNT_W'(DEPTH));
        end else begin
            rx_req = rx_nonempty;
            tx_req = (tx_count == '0);
        end
    end

    // R8: once raised in burst style the request holds until empty
    a_r8_hold_until_empty: assert property (@(posedge clk) disable iff (rst)
        (rx_req && burst) |=> (rx_req || rx_count == '0 || !burst));

    // R9: timeout with data raises the request at the next edge
    a_r9_timeout_raise: assert property (@(posedge clk) disable iff (rst)
        (burst && rx_timeout && rx_nonempty && !flush_rx) |=> (rx_req || rx_count == '0 || !burst));

    // R14: a receive flush drops any latched request
    a_r14_flush_drop: assert property (@(posedge clk) disable iff (rst)
        flush_rx |=> !rx_req);

endmodule

// File: rtl/uart_fifo_dma.sv
module uart_fifo_dma
    import uart_fifo_dma_pkg::*;
#(
    parameter int DEPTH     = 32,
    parameter int DATA_W    = 8,
    parameter int ERR_W     = 3,
    parameter bit RX_ERR_EN = 1'b1,
    localparam int CNT_W    = $clog2(DEPTH + 1),
    localparam int RX_W     = RX_ERR_EN ? (DATA_W + ERR_W) : DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_we,
    input  logic [31:0]       ctl_wdata,
    input  logic              rx_push,
    input  logic [DATA_W-1:0] rx_push_data,
    input  logic [ERR_W-1:0]  rx_push_err,
    input  logic              rx_pop,
    output logic [DATA_W-1:0] rx_pop_data,
    output logic [ERR_W-1:0]  rx_pop_err,
    input  logic              tx_push,
    input  logic [DATA_W-1:0] tx_push_data,
    input  logic              tx_pop,
    output logic [DATA_W-1:0] tx_pop_data,
    input  logic              rx_timeout,
    output logic              rx_dma_req,
    output logic              tx_dma_req,
    output logic              rx_trig,
    output logic [CNT_W-1:0]  rx_count,
    output logic [CNT_W-1:0]  tx_count,
    output logic              rx_overrun,
    output logic              tx_overrun
);

    ctl_state_t      ctl;
    flush_t          flush;
    logic [RX_W-1:0] rx_in, rx_out;
    logic            unused_rsvd;

    // Reserved control bits are not decoded
    assign unused_rsvd = ^{ctl_wdata[31:8], ctl_wdata[5:4]};

    ufd_ctrl u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .we    (ctl_we),
        .wbyte (ctl_wdata[7:0]),
        .ctl   (ctl),
        .flush (flush)
    );

    generate
        if (RX_ERR_EN) begin : g_rx_err
            assign rx_in       = {rx_push_err, rx_push_data};
            assign rx_pop_data = rx_out[DATA_W-1:0];
            assign rx_pop_err  = rx_out[RX_W-1:DATA_W];
        end else begin : g_rx_plain
            logic unused_err;
            assign unused_err  = ^rx_push_err;
            assign rx_in       = rx_push_data;
            assign rx_pop_data = rx_out;
            assign rx_pop_err  = '0;
        end
    endgenerate

    ufd_fifo #(.WIDTH(RX_W), .DEPTH(DEPTH)) u_rx_q (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush.rx),
        .single    (!ctl.fifo_on),
        .push      (rx_push),
        .push_data (rx_in),
        .pop       (rx_pop),
        .pop_data  (rx_out),
        .count     (rx_count),
        .overrun   (rx_overrun)
    );

    ufd_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_tx_q (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush.tx),
        .single    (!ctl.fifo_on),
        .push      (tx_push),
        .push_data (tx_push_data),
        .pop       (tx_pop),
        .pop_data  (tx_pop_data),
        .count     (tx_count),
        .overrun   (tx_overrun)
    );

    ufd_dma #(.DEPTH(DEPTH)) u_dma (
        .clk        (clk),
        .rst        (rst),
        .ctl        (ctl),
        .flush_rx   (flush.rx),
        .rx_count   (rx_count),
        .tx_count   (tx_count),
        .rx_timeout (rx_timeout),
        .rx_trig    (rx_trig),
        .rx_req     (rx_dma_req),
        .tx_req     (tx_dma_req)
    );

    // R3: changing the enable bit empties both queues
    a_r3_toggle_flush: assert property (@(posedge clk) disable iff (rst)
        (ctl_we && (ctl_wdata[CTL_EN_BIT] != ctl.fifo_on)) |=> (rx_count == '0 && tx_count == '0));

    // R2: with queuing off neither queue holds more than one entry
    a_r2_single_slot: assert property (@(posedge clk) disable iff (rst)
        (!ctl.fifo_on && !ctl_we) |=> (rx_count <= CNT_W'(1) && tx_count <= CNT_W'(1)));

endmodule

// File: tb/uart_fifo_dma_bench.sv
module uart_fifo_dma_bench;

    localparam int DEPTH = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctl_we = 1'b0;
    logic [31:0] ctl_wdata = '0;
    logic        rx_push = 1'b0;
    logic [7:0]  rx_push_data = '0;
    logic [2:0]  rx_push_err = '0;
    logic        rx_pop = 1'b0;
    logic [7:0]  rx_pop_data;
    logic [2:0]  rx_pop_err;
    logic        tx_push = 1'b0;
    logic [7:0]  tx_push_data = '0;
    logic        tx_pop = 1'b0;
    logic [7:0]  tx_pop_data;
    logic        rx_timeout = 1'b0;
    logic        rx_dma_req, tx_dma_req, rx_trig;
    logic [5:0]  rx_count, tx_count;
    logic        rx_overrun, tx_overrun;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    uart_fifo_dma u_uart_fifo_dma (
        .clk          (clk),
        .rst          (rst),
        .ctl_we       (ctl_we),
        .ctl_wdata    (ctl_wdata),
        .rx_push      (rx_push),
        .rx_push_data (rx_push_data),
        .rx_push_err  (rx_push_err),
        .rx_pop       (rx_pop),
        .rx_pop_data  (rx_pop_data),
        .rx_pop_err   (rx_pop_err),
        .tx_push      (tx_push),
        .tx_push_data (tx_push_data),
        .tx_pop       (tx_pop),
        .tx_pop_data  (tx_pop_data),
        .rx_timeout   (rx_timeout),
        .rx_dma_req   (rx_dma_req),
        .tx_dma_req   (tx_dma_req),
        .rx_trig      (rx_trig),
        .rx_count     (rx_count),
        .tx_count     (tx_count),
        .rx_overrun   (rx_overrun),
        .tx_overrun   (tx_overrun)
    );

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Stimulus helpers: drive on the falling edge, sample 1 ns after the rising edge
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr_ctl(logic [31:0] v);
        @(negedge clk);
        ctl_we = 1'b1; ctl_wdata = v;
        step();
        ctl_we = 1'b0; ctl_wdata = '0;
    endtask

    task automatic push_rx(logic [7:0] d, logic [2:0] e);
        @(negedge clk);
        rx_push = 1'b1; rx_push_data = d; rx_push_err = e;
        step();
        rx_push = 1'b0;
    endtask

    task automatic pop_rx();
        @(negedge clk);
        rx_pop = 1'b1;
        step();
        rx_pop = 1'b0;
    endtask

    task automatic push_tx(logic [7:0] d);
        @(negedge clk);
        tx_push = 1'b1; tx_push_data = d;
        step();
        tx_push = 1'b0;
    endtask

    task automatic pop_tx();
        @(negedge clk);
        tx_pop = 1'b1;
        step();
        tx_pop = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", "rx_count", rx_count, 0);
        chk("R1", "tx_count", tx_count, 0);
        chk("R1", "rx_dma_req", rx_dma_req, 0);
        chk("R1", "tx_dma_req", tx_dma_req, 1);
        chk("R1", "rx_trig", rx_trig, 0);
        chk("R1", "overruns", {rx_overrun, tx_overrun}, 0);
        chk("R1", "rx_pop_data", rx_pop_data, 0);
    endtask

    task automatic t_disabled();
        push_rx(8'h5A, 3'd2);
        chk("R2", "rx count one", rx_count, 1);
        chk("R2", "rx req full slot", rx_dma_req, 1);
        chk("R6", "trig at one when off", rx_trig, 1);
        push_rx(8'h11, 3'd0);
        chk("R12", "slot overflow dropped", rx_count, 1);
        chk("R12", "rx overrun", rx_overrun, 1);
        // enable low with clear bits and mode bit set: nothing may be emptied
        wr_ctl(32'h0000_000E);
        chk("R4", "rx slot kept", rx_count, 1);
        chk("R2", "rx req ignores mode bit", rx_dma_req, 1);
        chk("R2", "tx req empty slot", tx_dma_req, 1);
        pop_rx();
        chk("R11", "rx data", rx_pop_data, 8'h5A);
        chk("R11", "rx err", rx_pop_err, 2);
        chk("R2", "rx req after pop", rx_dma_req, 0);
        pop_rx();
        chk("R12", "empty pop keeps data", rx_pop_data, 8'h5A);
        push_tx(8'h33);
        chk("R2", "tx req when slot full", tx_dma_req, 0);
        push_tx(8'h44);
        chk("R12", "tx overrun", tx_overrun, 1);
        chk("R12", "tx count one", tx_count, 1);
        pop_tx();
        chk("R11", "tx data", tx_pop_data, 8'h33);
        chk("R2", "tx req after pop", tx_dma_req, 1);
        push_rx(8'h21, 3'd0);
        push_tx(8'h22);
    endtask

    task automatic t_enable_flush();
        chk("R3", "pre rx count", rx_count, 1);
        wr_ctl(32'h0000_0001);
        chk("R3", "rx emptied on enable", rx_count, 0);
        chk("R3", "tx emptied on enable", tx_count, 0);
        chk("R3", "overruns cleared", {rx_overrun, tx_overrun}, 0);
        for (int i = 0; i < 3; i++) push_rx(8'(i), 3'd0);
        chk("R3", "queue refilled", rx_count, 3);
        // disable with a push in the same cycle
        @(negedge clk);
        ctl_we = 1'b1; ctl_wdata = 32'h0; rx_push = 1'b1; rx_push_data = 8'h77;
        step();
        ctl_we = 1'b0; rx_push = 1'b0;
        chk("R3", "disable empties, push dropped", rx_count, 0);
        @(negedge clk);
        ctl_we = 1'b1; ctl_wdata = 32'h1; tx_push = 1'b1; tx_push_data = 8'h78;
        step();
        ctl_we = 1'b0; tx_push = 1'b0;
        chk("R3", "enable drops same-cycle push", tx_count, 0);
    endtask

    task automatic t_order();
        wr_ctl(32'h0000_0007);
        for (int i = 0; i < DEPTH; i++) push_rx(8'(i * 7 + 3), 3'(i % 8));
        chk("R11", "full count", rx_count, DEPTH);
        chk("R12", "no overrun yet", rx_overrun, 0);
        push_rx(8'hEE, 3'd7);
        chk("R12", "full push dropped", rx_count, DEPTH);
        chk("R12", "overrun set", rx_overrun, 1);
        for (int i = 0; i < DEPTH; i++) begin
            pop_rx();
            chk("R11", "order data", rx_pop_data, (i * 7 + 3) & 8'hFF);
            chk("R11", "order err", rx_pop_err, i % 8);
        end
        chk("R7", "rx req empty", rx_dma_req, 0);
        pop_rx();
        chk("R12", "empty pop keeps last", rx_pop_data, ((DEPTH - 1) * 7 + 3) & 8'hFF);
        chk("R12", "overrun sticky", rx_overrun, 1);
    endtask

    task automatic t_mode0_flush();
        wr_ctl(32'h0000_0007);
        chk("R5", "clear bits empty rx", rx_count, 0);
        chk("R7", "tx req empty", tx_dma_req, 1);
        push_rx(8'h01, 3'd0);
        chk("R7", "rx req one entry", rx_dma_req, 1);
        push_rx(8'h02, 3'd0);
        push_tx(8'h10);
        chk("R7", "tx req not empty", tx_dma_req, 0);
        wr_ctl(32'h0000_0005);
        chk("R5", "tx emptied", tx_count, 0);
        chk("R5", "rx untouched", rx_count, 2);
        push_tx(8'h11);
        wr_ctl(32'h0000_0003);
        chk("R5", "rx emptied", rx_count, 0);
        chk("R5", "tx untouched", tx_count, 1);
        wr_ctl(32'h0000_0005);
    endtask

    task automatic t_trigger();
        int lv [4] = '{1, 16, 24, 28};
        for (int s = 0; s < 4; s++) begin
            wr_ctl(32'h0000_0003 | (32'(s) << 6));
            for (int i = 0; i < lv[s] - 1; i++) push_rx(8'(i), 3'd0);
            chk("R6", $sformatf("below level sel %0d", s), rx_trig, 0);
            push_rx(8'hAA, 3'd0);
            chk("R6", $sformatf("at level sel %0d", s), rx_trig, 1);
        end
        wr_ctl(32'h0000_0003);
    endtask

    task automatic t_burst_rx();
        wr_ctl(32'h0000_004F);
        for (int i = 0; i < 15; i++) push_rx(8'(i), 3'd0);
        chk("R8", "no req below level", rx_dma_req, 0);
        push_rx(8'h0F, 3'd0);
        chk("R8", "req at level", rx_dma_req, 1);
        for (int i = 0; i < 10; i++) pop_rx();
        chk("R8", "req held below level", rx_dma_req, 1);
        for (int i = 0; i < 5; i++) pop_rx();
        chk("R8", "req held at one entry", rx_dma_req, 1);
        pop_rx();
        chk("R8", "req drops on empty", rx_dma_req, 0);
        push_rx(8'h01, 3'd0);
        chk("R8", "no re-latch on one entry", rx_dma_req, 0);
        for (int i = 0; i < 15; i++) push_rx(8'(i), 3'd0);
        pop_rx();
        chk("R14", "latched before flush", rx_dma_req, 1);
        wr_ctl(32'h0000_004B);
        chk("R14", "flush clears request", rx_dma_req, 0);
        push_rx(8'h02, 3'd0);
        chk("R14", "stays clear after flush", rx_dma_req, 0);
        wr_ctl(32'h0000_004B);
    endtask

    task automatic t_timeout();
        @(negedge clk);
        rx_timeout = 1'b1;
        step();
        rx_timeout = 1'b0;
        chk("R9", "timeout on empty queue", rx_dma_req, 0);
        for (int i = 0; i < 3; i++) push_rx(8'(i), 3'd0);
        chk("R9", "no req before timeout", rx_dma_req, 0);
        @(negedge clk);
        rx_timeout = 1'b1;
        step();
        rx_timeout = 1'b0;
        chk("R9", "req after timeout", rx_dma_req, 1);
        pop_rx();
        pop_rx();
        chk("R9", "req held", rx_dma_req, 1);
        pop_rx();
        chk("R9", "req drops on empty", rx_dma_req, 0);
    endtask

    task automatic t_burst_tx();
        wr_ctl(32'h0000_004D);
        chk("R10", "req on empty", tx_dma_req, 1);
        for (int i = 0; i < DEPTH - 1; i++) push_tx(8'(i));
        chk("R10", "req one slot free", tx_dma_req, 1);
        push_tx(8'hFF);
        chk("R10", "no req when full", tx_dma_req, 0);
        pop_tx();
        chk("R10", "req after pop", tx_dma_req, 1);
        chk("R11", "tx first out", tx_pop_data, 0);
        wr_ctl(32'h0000_0005);
    endtask

    task automatic t_reserved();
        wr_ctl(32'h0000_0007);
        push_tx(8'h12);
        // bits 5:4 and 31:8 set; effective byte is enable, burst mode, threshold 1
        wr_ctl(32'hA5A5_0039);
        chk("R13", "no flush from reserved bits", tx_count, 1);
        chk("R13", "burst tx req", tx_dma_req, 1);
        push_rx(8'h09, 3'd0);
        chk("R13", "threshold one selected", rx_trig, 1);
        chk("R13", "burst rx req", rx_dma_req, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        step();
        t_reset();
        t_disabled();
        t_enable_flush();
        t_order();
        t_mode0_flush();
        t_trigger();
        t_burst_rx();
        t_timeout();
        t_burst_tx();
        t_reserved();
        finish_run();
    end

endmodule